// File: doc/BRIEF.md
# Double-Buffered SPI Master Transfer Engine

This block is an SPI master that sends and receives one character at a time. A host writes 16-bit words into a single data port. Each word goes either straight into the transmit shift register or into one hidden holding buffer, depending on which of them is occupied. When a character finishes and a word is waiting in the holding buffer, that word moves into the shift register and the next character starts with no idle gap. A single-cycle DMA request strobe and a transmit-empty interrupt strobe tell the host that the data port can take another word.

Received bits are shifted in MSB first. The finished character is placed in a receive buffer that the host reads through `rd_data`/`rd_en`. The receive side reports an empty flag, a level interrupt and a sticky overrun flag. Configuration inputs set the character length, the serial clock polarity, the phase and the prescaler. They are expected to be changed only while no transfer is running.

The transfer kernel is a three-state machine:
- `ST_IDLE` holds `sclk` at its idle level.
- `ST_LEAD` is the first half of a bit.
- `ST_TRAIL` is the second half of a bit.

Its transitions are:
- IDLE→LEAD when a word is loaded.
- LEAD→TRAIL when the half-period tick arrives. This is the sampling point.
- TRAIL→LEAD on a tick when more bits remain, or at the end of a character when a word is loaded in the same cycle.
- TRAIL→IDLE on a tick at the end of a character when no word is loaded.

Top module: `spi_dbuf_master`

## Requirements
- R1: A write while the engine is idle and the holding buffer is empty loads the word straight into the shift register and starts a character in the next cycle. `tx_full` stays 0. A write in the last cycle of a character with the holding buffer empty is also treated as a direct load.
- R2: Every load of the shift register produces a one-cycle `dma_req` pulse if `cfg_dma_en` is 1, and a one-cycle `tx_empty_irq` pulse if `cfg_tx_ie` is 1. Both pulses appear in the cycle after the load decision. When an enable is 0, its strobe never pulses.
- R3: A write while a character is in progress and the holding buffer is empty stores the word in the holding buffer, and `tx_full` is 1 from the next cycle.
- R4: A write while `tx_full` is 1 is ignored. The held word is the one transmitted next, and no extra character is sent.
- R5: At the end of a character with the holding buffer full, the held word becomes the next character at once, and `tx_full` clears in the same cycle as the R2 strobes. With `n` = `cfg_len_m1`+1 bits and `P` = `cfg_prescale`, the strobe for a direct load and the strobe for the promotion that follows it are exactly 2·n·(P+1) cycles apart.
- R6: A character is `cfg_len_m1`+1 bits long (`cfg_len_m1` 0..15 gives 1..16 bits). `mosi` carries word bits [`cfg_len_m1`:0], MSB first, and is 0 while idle.
- R7: `sclk` rests at `cfg_cpol` while idle. Each half of a serial bit lasts `cfg_prescale`+1 clock cycles.
- R8: With `cfg_cpha`=0, `miso` is sampled on the edge that leaves the idle level, and `mosi` changes on the edge that returns to it. With `cfg_cpha`=1, it is the other way round. `mosi` is stable across each sampling edge.
- R9: At the end of each character the received bits are placed right-aligned in `rd_data`, with the upper bits 0, and `rx_empty` falls. A one-cycle `rd_en` sets `rx_empty` again.
- R10: When a character ends while the previous word is still unread, `rx_overrun` sets and the new word replaces the old one. `rd_en` clears `rx_overrun`.
- R11: `rx_full_irq` is 1 exactly while `cfg_rx_ie` is 1 and `rx_empty` is 0.
- R12: After reset these outputs are all 0:
  - `tx_full`
  - `dma_req`
  - `tx_empty_irq`
  - `rx_overrun`
  - `rx_full_irq`
  - `mosi`

  `rx_empty` is 1, and `sclk` equals `cfg_cpol` one cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_m1 | input | 4 | Character length minus one |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | Sampling edge select (0: leading, 1: trailing) |
| cfg_prescale | input | 8 | Half-bit length minus one, in clock cycles |
| cfg_dma_en | input | 1 | Enables the `dma_req` strobe |
| cfg_tx_ie | input | 1 | Enables the `tx_empty_irq` strobe |
| cfg_rx_ie | input | 1 | Enables `rx_full_irq` |
| wr_en | input | 1 | Host write strobe for the data port |
| wr_data | input | 16 | Word written by the host |
| rd_en | input | 1 | Host read strobe; consumes the receive buffer |
| miso | input | 1 | Serial data from the slave |
| rd_data | output | 16 | Receive buffer contents |
| tx_full | output | 1 | Holding buffer occupied |
| dma_req | output | 1 | One-cycle transmit DMA request |
| tx_empty_irq | output | 1 | One-cycle transmit-empty interrupt |
| rx_empty | output | 1 | Receive buffer has no unread word |
| rx_full_irq | output | 1 | Receive interrupt (level) |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |

## Verification
The bench sweeps every character length, prescaler values 0 to 2, and all four polarity and phase combinations. For each combination it sends a direct-loaded word followed at once by a parked word. It decodes `mosi` on the sampling edges it derives itself. The bench also checks the following corner cases:
- **Strobe spacing.** The spacing of the strobes is checked against 2·n·(P+1). A design that promotes one bit early or late, or that inserts an idle gap, shifts that count.
- **Inverted loopback.** `miso` is fed back inverted for some combinations, so reversed bit order, a wrong sampling edge or stale upper bits appear as a wrong received word.
- **Write to a full holding buffer.** A third write arrives while the holding buffer is full. A design that overwrites the buffer transmits the wrong second word, and one that queues the write sends an extra character.
- **Overrun and flags.** The bench checks the overrun flag, the replaced data and the disabled strobes. A design that keeps the old word, or that pulses with its enable off, is caught.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

    // Kernel states: one half of a serial bit per active state.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/spi_dbuf_clkdiv.sv
module spi_dbuf_clkdiv #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    localparam logic [PRE_W-1:0] CNT_ONE = PRE_W'(1);

    logic [PRE_W-1:0] cnt_q;

    // Tick ends a half-bit of prescale+1 cycles.
    assign tick = run && (cnt_q == prescale);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end
endmodule

// File: rtl/spi_dbuf_txhold.sv
module spi_dbuf_txhold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shifter_idle,
    input  logic              char_end,
    output logic              load_go,
    output logic [DATA_W-1:0] load_word,
    output logic              tx_full
);
    logic              full_q;
    logic [DATA_W-1:0] hold_q;
    logic              slot_free;
    logic              direct_wr;
    logic              park_wr;
    logic              promote;

    // The shift register can take a word now if it is idle, or if its
    // character ends in this very cycle and nothing waits in the buffer.
    assign slot_free = !full_q && (shifter_idle || char_end);
    assign direct_wr = wr_en && slot_free;
    assign park_wr   = wr_en && !full_q && !shifter_idle && !char_end;
    assign promote   = char_end && full_q;

    assign load_go   = direct_wr || promote;
    assign load_word = promote ? hold_q : wr_data;
    assign tx_full   = full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            hold_q <= '0;
        end else begin
            if (promote) begin
                full_q <= 1'b0;
            end
            if (park_wr) begin
                hold_q <= wr_data;
                full_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_dbuf_engine.sv
module spi_dbuf_engine
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_go,
    input  logic [DATA_W-1:0] load_word,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              busy,
    output logic              char_end,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi
);
    localparam logic [LEN_W-1:0] BIT_ONE = LEN_W'(1);

    xfer_state_e       state_q, state_d;
    logic [LEN_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              sclk_q;
    logic              last_bit;
    logic              start_char;

    assign last_bit   = (bit_q == len_m1);
    assign char_end   = (state_q == ST_TRAIL) && tick && last_bit;
    assign start_char = load_go && ((state_q == ST_IDLE) || char_end);
    assign busy       = (state_q != ST_IDLE);
    assign rx_word    = rx_sh_q;
    assign sclk       = sclk_q;
    assign mosi       = busy ? tx_sh_q[len_m1] : 1'b0;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_go) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (!last_bit || load_go) state_d = ST_LEAD;
                    else                      state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sclk_q  <= 1'b0;
        end else begin
            unique case (state_d)
                ST_LEAD:  sclk_q <= cpol ^ cpha;
                ST_TRAIL: sclk_q <= cpol ^ ~cpha;
                default:  sclk_q <= cpol;
            endcase
            if (start_char) begin
                tx_sh_q <= load_word;
                rx_sh_q <= '0;
                bit_q   <= '0;
            end else if ((state_q == ST_LEAD) && tick) begin
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
            end else if ((state_q == ST_TRAIL) && tick && !last_bit) begin
                tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                bit_q   <= bit_q + BIT_ONE;
            end
        end
    end
endmodule

// File: rtl/spi_dbuf_rxbuf.sv
module spi_dbuf_rxbuf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_end,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rd_en,
    input  logic              rx_ie,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              rx_irq
);
    logic [DATA_W-1:0] buf_q;
    logic              valid_q;
    logic              ovr_q;

    assign rd_data    = buf_q;
    assign rx_empty   = !valid_q;
    assign rx_overrun = ovr_q;
    assign rx_irq     = rx_ie && valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (char_end) begin
            buf_q   <= rx_word;
            valid_q <= 1'b1;
            if (valid_q && !rd_en) ovr_q <= 1'b1;
            else if (rd_en)        ovr_q <= 1'b0;
        end else if (rd_en) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
    parameter  int DATA_W = 16,
    parameter  int PRE_W  = 8,
    localparam int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic              cfg_dma_en,
    input  logic              cfg_tx_ie,
    input  logic              cfg_rx_ie,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              miso,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_full,
    output logic              dma_req,
    output logic              tx_empty_irq,
    output logic              rx_empty,
    output logic              rx_full_irq,
    output logic              rx_overrun,
    output logic              sclk,
    output logic              mosi
);
    logic              eng_busy;
    logic              eng_tick;
    logic              char_end;
    logic              load_go;
    logic [DATA_W-1:0] load_word;
    logic [DATA_W-1:0] rx_word;
    logic              req_q;
    logic              irq_q;

    spi_dbuf_clkdiv #(.PRE_W(PRE_W)) clkdiv_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_busy),
        .prescale (cfg_prescale),
        .tick     (eng_tick)
    );

    spi_dbuf_txhold #(.DATA_W(DATA_W)) txhold_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .shifter_idle (!eng_busy),
        .char_end     (char_end),
        .load_go      (load_go),
        .load_word    (load_word),
        .tx_full      (tx_full)
    );

    spi_dbuf_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (eng_tick),
        .load_go   (load_go),
        .load_word (load_word),
        .len_m1    (cfg_len_m1),
        .cpol      (cfg_cpol),
        .cpha      (cfg_cpha),
        .miso      (miso),
        .busy      (eng_busy),
        .char_end  (char_end),
        .rx_word   (rx_word),
        .sclk      (sclk),
        .mosi      (mosi)
    );

    spi_dbuf_rxbuf #(.DATA_W(DATA_W)) rxbuf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_end   (char_end),
        .rx_word    (rx_word),
        .rd_en      (rd_en),
        .rx_ie      (cfg_rx_ie),
        .rd_data    (rd_data),
        .rx_empty   (rx_empty),
        .rx_overrun (rx_overrun),
        .rx_irq     (rx_full_irq)
    );

    // Request strobes share the edge that loads the shift register
    // and, on promotion, clears the full flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            req_q <= load_go && cfg_dma_en;
            irq_q <= load_go && cfg_tx_ie;
        end
    end

    assign dma_req      = req_q;
    assign tx_empty_irq = irq_q;
endmodule

// File: rtl/spi_dbuf_checker.sv
module spi_dbuf_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic tx_full,
    input logic dma_req,
    input logic tx_empty_irq,
    input logic cfg_dma_en,
    input logic cfg_tx_ie,
    input logic cfg_cpol,
    input logic sclk,
    input logic rx_empty,
    input logic rx_overrun
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req); // R2

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_dma_en) |-> !dma_req); // R2

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_tx_ie) |-> !tx_empty_irq); // R2

    AST_FULL_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> busy); // R3

    AST_PROMOTE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_full) && $past(cfg_dma_en)) |-> dma_req); // R5

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(rst_n) && $stable(cfg_cpol))
            |-> (sclk == cfg_cpol)); // R7

    AST_OVR_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> !rx_empty); // R10
endmodule

bind spi_dbuf_master spi_dbuf_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (eng_busy),
    .tx_full      (tx_full),
    .dma_req      (dma_req),
    .tx_empty_irq (tx_empty_irq),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_tx_ie    (cfg_tx_ie),
    .cfg_cpol     (cfg_cpol),
    .sclk         (sclk),
    .rx_empty     (rx_empty),
    .rx_overrun   (rx_overrun)
);

// File: tb/spi_dbuf_master_tb_top.sv
module spi_dbuf_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_len_m1 = '0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic [7:0]  cfg_prescale = '0;
    logic        cfg_dma_en = 1'b0;
    logic        cfg_tx_ie = 1'b0;
    logic        cfg_rx_ie = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        inv = 1'b0;
    logic        miso;
    logic [15:0] rd_data;
    logic        tx_full, dma_req, tx_empty_irq, rx_empty, rx_full_irq, rx_overrun, sclk, mosi;

    int n_chk = 0;
    int n_bad = 0;

    // Monitor state
    int          cyc = 0;
    int          req_n, req_t0, req_t1, irq_n;
    int          tog_n, last_tog, half_meas;
    logic [15:0] cap_sh;
    int          cap_n;
    logic        sclk_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign miso = mosi ^ inv;

    spi_dbuf_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len_m1(cfg_len_m1), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_prescale(cfg_prescale), .cfg_dma_en(cfg_dma_en),
        .cfg_tx_ie(cfg_tx_ie), .cfg_rx_ie(cfg_rx_ie), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .miso(miso), .rd_data(rd_data), .tx_full(tx_full),
        .dma_req(dma_req), .tx_empty_irq(tx_empty_irq), .rx_empty(rx_empty),
        .rx_full_irq(rx_full_irq), .rx_overrun(rx_overrun), .sclk(sclk), .mosi(mosi)
    );

    // Slave-side observer: counts strobes, measures sclk, decodes mosi
    // on the sampling edge implied by cpol/cpha (R8).
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (dma_req) begin
            if (req_n == 0) req_t0 = cyc;
            else if (req_n == 1) req_t1 = cyc;
            req_n = req_n + 1;
        end
        if (tx_empty_irq) irq_n = irq_n + 1;
        if (sclk !== sclk_prev) begin
            tog_n = tog_n + 1;
            if (tog_n == 2) half_meas = cyc - last_tog;
            last_tog = cyc;
            if ((sclk != cfg_cpol) == (cfg_cpha == 1'b0)) begin
                cap_sh = {cap_sh[14:0], mosi};
                cap_n  = cap_n + 1;
            end
        end
        sclk_prev = sclk;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mon_clear();
        req_n = 0; req_t0 = 0; req_t1 = 0; irq_n = 0;
        tog_n = 0; last_tog = 0; half_meas = 0;
        cap_sh = '0; cap_n = 0; sclk_prev = sclk;
    endtask

    task automatic wait_rx_word();
        for (int k = 0; k < 4000 && rx_empty; k++) @(negedge clk);
    endtask

    task automatic wait_overrun();
        for (int k = 0; k < 4000 && !rx_overrun; k++) @(negedge clk);
    endtask

    task automatic read_word();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [15:0] len_mask(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic setup(input int lm1, input int pre, input bit pol, input bit pha,
                         input bit inv_b, input bit dma, input bit txie);
        @(negedge clk);
        cfg_len_m1 = 4'(lm1); cfg_prescale = 8'(pre); cfg_cpol = pol; cfg_cpha = pha;
        cfg_dma_en = dma; cfg_tx_ie = txie; inv = inv_b;
        repeat (2) @(negedge clk);
        mon_clear();
    endtask

    // A direct-loaded word followed at once by a parked word.
    task automatic run_pair(input int lm1, input int pre, input bit pol, input bit pha,
                            input bit inv_b, input bit dma, input bit txie,
                            input logic [15:0] a, input logic [15:0] b);
        int          nb  = lm1 + 1;
        logic [15:0] msk = len_mask(lm1 + 1);
        logic [15:0] ix  = inv_b ? 16'hFFFF : 16'h0000;
        setup(lm1, pre, pol, pha, inv_b, dma, txie);
        wr_en = 1'b1; wr_data = a;
        @(negedge clk);
        chk("R1 tx_full after direct load", 32'(tx_full), 0);
        chk("R2 dma_req after direct load", 32'(dma_req), 32'(dma));
        chk("R2 tx_empty_irq after direct load", 32'(tx_empty_irq), 32'(txie));
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R3 tx_full after parked write", 32'(tx_full), 1);
        chk("R2 dma_req single cycle", 32'(dma_req), 0);
        wait_rx_word();
        chk("R9 rx_empty after first char", 32'(rx_empty), 0);
        chk("R9 first received word", 32'(rd_data), 32'((a ^ ix) & msk));
        chk("R6 first mosi bit count", 32'(cap_n), 32'(nb));
        chk("R6 first mosi word", 32'(cap_sh & msk), 32'(a & msk));
        chk("R7 half period", 32'(half_meas), 32'(pre + 1));
        chk("R5 tx_full cleared on promotion", 32'(tx_full), 0);
        cap_sh = '0; cap_n = 0;
        read_word();
        chk("R9 rx_empty after read", 32'(rx_empty), 1);
        wait_rx_word();
        chk("R9 second received word", 32'(rd_data), 32'((b ^ ix) & msk));
        chk("R8 second mosi word", 32'(cap_sh & msk), 32'(b & msk));
        chk("R2 dma_req pulse count", 32'(req_n), dma ? 32'd2 : 32'd0);
        chk("R2 tx_empty_irq pulse count", 32'(irq_n), txie ? 32'd2 : 32'd0);
        if (dma) chk("R5 promotion spacing", 32'(req_t1 - req_t0), 32'(2 * nb * (pre + 1)));
        chk("R10 no overrun when read in time", 32'(rx_overrun), 0);
        repeat (2) @(negedge clk);
        chk("R7 sclk idle level", 32'(sclk), 32'(pol));
        chk("R6 mosi idle", 32'(mosi), 0);
        read_word();
    endtask

    initial begin : watchdog
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int idx = 0;
        mon_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12 reset state
        chk("R12 tx_full", 32'(tx_full), 0);
        chk("R12 rx_empty", 32'(rx_empty), 1);
        chk("R12 rx_overrun", 32'(rx_overrun), 0);
        chk("R12 dma_req", 32'(dma_req), 0);
        chk("R12 tx_empty_irq", 32'(tx_empty_irq), 0);
        chk("R12 rx_full_irq", 32'(rx_full_irq), 0);
        chk("R12 sclk", 32'(sclk), 32'(cfg_cpol));
        chk("R12 mosi", 32'(mosi), 0);

        // Sweep: every length, prescale 0..2, all polarity/phase pairs.
        for (int pha = 0; pha < 2; pha++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int pre = 0; pre < 3; pre++) begin
                    for (int lm1 = 0; lm1 < 16; lm1++) begin
                        run_pair(lm1, pre, pol[0], pha[0], (idx % 3) == 0, 1'b1, 1'b1,
                                 16'hA5C3 ^ 16'(idx * 16'h1357),
                                 16'h3C96 ^ 16'(idx * 16'h0F1D));
                        idx++;
                    end
                end
            end
        end

        // R2: strobes disabled
        run_pair(9, 1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0357, 16'h02AC);

        // R4: third write while holding buffer full is ignored
        setup(7, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        wr_en = 1'b1; wr_data = 16'h005A;
        @(negedge clk); wr_data = 16'h00C3;
        @(negedge clk); wr_data = 16'h00FF;
        @(negedge clk); wr_en = 1'b0;
        wait_rx_word();
        chk("R4 first word", 32'(rd_data), 32'h5A);
        read_word();
        wait_rx_word();
        chk("R4 held word kept", 32'(rd_data), 32'hC3);
        read_word();
        repeat (8 * 2 * 2 + 10) @(negedge clk);
        chk("R4 no extra character", 32'(rx_empty), 1);
        chk("R4 strobe count", 32'(req_n), 2);

        // R10/R11: overrun and receive interrupt
        setup(11, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        cfg_rx_ie = 1'b1;
        wr_en = 1'b1; wr_data = 16'h0ABC;
        @(negedge clk); wr_data = 16'h0123;
        @(negedge clk); wr_en = 1'b0;
        chk("R11 rx_full_irq while empty", 32'(rx_full_irq), 0);
        wait_rx_word();
        chk("R11 rx_full_irq with data", 32'(rx_full_irq), 1);
        chk("R10 first word", 32'(rd_data), 32'hABC);
        wait_overrun();
        chk("R10 overrun set", 32'(rx_overrun), 1);
        chk("R10 new word replaces old", 32'(rd_data), 32'h123);
        read_word();
        chk("R10 overrun cleared by read", 32'(rx_overrun), 0);
        chk("R9 empty after read", 32'(rx_empty), 1);
        chk("R11 rx_full_irq after read", 32'(rx_full_irq), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule